// File: doc/BRIEF.md
# Word-Parallel Bit-Serial Associative Array

This block holds a small array of data words, each paired with its own one-bit processing element. Every working cycle, the same bit position is taken from all words at once and handed to the processing elements. An operation on a field that is W bits wide therefore takes W cycles, however many words the array holds. The array answers two commands. A masked equality search marks every word whose field equals a comparand. A field add sums two fields of every word and stores the result in a third field of the same word.

A host loads words through a one-cycle write command and reads any word back through a combinational read port. A search or add command carries its own field offsets and its width. The block accepts a command only while it is idle. The search result appears as one tag bit per word, together with an any-match flag. A one-cycle done pulse marks the end of each search or add.

The controller is a four-state machine. ST_IDLE accepts a command. A write stays in ST_IDLE, a search moves to ST_SEARCH and an add moves to ST_ADD. ST_SEARCH and ST_ADD process one slice per cycle and leave for ST_DONE after the last slice. ST_DONE lasts one cycle and returns to ST_IDLE.

Top module: `bitslice_assoc_proc`

## Requirements
- R1: After reset, busy, done, any_match and all tags are 0, and every word reads back as 0.
- R2: When idle, a command with cmd_op=0 (write) stores cmd_data into the word selected by cmd_word. The new value is visible on rd_data from the next cycle, and no other word changes.
- R3: cmd_op=1 (search) with width W=cmd_wm1+1 sets tags[w] to 1 exactly when, for every i<W where cmd_mask[i]=1, bit (cmd_off_a+i) mod 32 of word w equals cmd_data[i]. any_match is 1 when at least one tag is 1.
- R4: A search with cmd_mask all zero sets every tag to 1.
- R5: cmd_op=2 (add) writes (A+B) mod 2^W into the S field of every word. A starts at cmd_off_a, B at cmd_off_b and S at cmd_off_s, all W bits wide. The final carry is discarded and bits outside S are unchanged.
- R6: An add whose S field is the same as its A field gives A+B in place (accumulate).
- R7: The block processes one bit-slice per cycle. busy is high from the cycle after acceptance, and done is a single-cycle pulse in the cycle that follows the W-th slice.
- R8: Commands presented while busy is high are ignored.
- R9: Tags change only because of a search. Write and add commands leave them as they are.
- R10: Field bit positions wrap from bit 31 to bit 0, for searches and for all three add fields.
- R11: cmd_op=3 is a no-op. It changes no word and no tag, and it produces no busy and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 write, 1 search, 2 add, 3 no-op |
| cmd_word | input | 4 | Word index for write |
| cmd_data | input | 32 | Write data, or search comparand (field-relative) |
| cmd_mask | input | 32 | Search enable per field bit (field-relative) |
| cmd_off_a | input | 5 | Search field or A field start bit |
| cmd_off_b | input | 5 | B field start bit |
| cmd_off_s | input | 5 | S field start bit |
| cmd_wm1 | input | 5 | Field width minus one |
| rd_word | input | 4 | Read word index |
| rd_data | output | 32 | Selected word contents |
| busy | output | 1 | Command in progress |
| done | output | 1 | Single-cycle completion pulse |
| tags | output | 16 | Per-word search result |
| any_match | output | 1 | OR of all tags |

## Verification
The bench builds the block with its default sizes of 16 words of 32 bits. At that size it can hold a bit-accurate software copy of the whole array and compare every word after each add. The 32-bit width allows a full-width add, where the discarded carry is visible. It also allows fields that start near bit 31, so wrap-around of A, S and search fields can be reached. Several words hold identical contents, so searches produce multi-bit tag vectors and not just single matches.

// File: rtl/bsap_pkg.sv
package bsap_pkg;
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SEARCH = 2'd1,
        OP_ADD    = 2'd2,
        OP_NOP    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_ADD,
        ST_DONE
    } state_e;
endpackage

// File: rtl/bsap_slice_mem.sv
module bsap_slice_mem #(
    parameter int unsigned NWORDS = 16,
    parameter int unsigned WBITS  = 32,
    parameter int unsigned IDXW   = $clog2(NWORDS),
    parameter int unsigned POSW   = $clog2(WBITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_we,
    input  logic [IDXW-1:0]   word_idx,
    input  logic [WBITS-1:0]  word_data,
    input  logic              slice_we,
    input  logic [POSW-1:0]   pos_a,
    input  logic [POSW-1:0]   pos_b,
    input  logic [POSW-1:0]   pos_s,
    input  logic [NWORDS-1:0] sum_bits,
    output logic [NWORDS-1:0] slice_a,
    output logic [NWORDS-1:0] slice_b,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [WBITS-1:0]  rd_data
);
    logic [WBITS-1:0] word_view [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WBITS-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (word_we && word_idx == IDXW'(w)) begin
                word_q <= word_data;
            end else if (slice_we) begin
                word_q[pos_s] <= sum_bits[w];
            end
        end

        assign slice_a[w]   = word_q[pos_a];
        assign slice_b[w]   = word_q[pos_b];
        assign word_view[w] = word_q;
    end

    assign rd_data = word_view[rd_idx];
endmodule

// File: rtl/bsap_pe_array.sv
module bsap_pe_array #(
    parameter int unsigned NWORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              search_init,
    input  logic              search_step,
    input  logic              add_init,
    input  logic              add_step,
    input  logic              cmp_bit,
    input  logic              mask_bit,
    input  logic [NWORDS-1:0] bit_a,
    input  logic [NWORDS-1:0] bit_b,
    output logic [NWORDS-1:0] sum_bits,
    output logic [NWORDS-1:0] tags
);
    for (genvar p = 0; p < NWORDS; p++) begin : g_pe
        logic tag_q;
        logic carry_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q   <= 1'b0;
                carry_q <= 1'b0;
            end else begin
                if (search_init) begin
                    tag_q <= 1'b1;
                end else if (search_step && mask_bit && (bit_a[p] != cmp_bit)) begin
                    tag_q <= 1'b0;
                end

                if (add_init) begin
                    carry_q <= 1'b0;
                end else if (add_step) begin
                    carry_q <= (bit_a[p] & bit_b[p]) | (carry_q & (bit_a[p] ^ bit_b[p]));
                end
            end
        end

        assign sum_bits[p] = bit_a[p] ^ bit_b[p] ^ carry_q;
        assign tags[p]     = tag_q;
    end
endmodule

// File: rtl/bsap_ctrl.sv
module bsap_ctrl
    import bsap_pkg::*;
#(
    parameter int unsigned WBITS = 32,
    parameter int unsigned POSW  = $clog2(WBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [WBITS-1:0] cmd_cmp,
    input  logic [WBITS-1:0] cmd_mask,
    input  logic [POSW-1:0]  cmd_off_a,
    input  logic [POSW-1:0]  cmd_off_b,
    input  logic [POSW-1:0]  cmd_off_s,
    input  logic [POSW-1:0]  cmd_wm1,
    output logic             word_we,
    output logic             search_init,
    output logic             search_step,
    output logic             add_init,
    output logic             add_step,
    output logic             cmp_bit,
    output logic             mask_bit,
    output logic [POSW-1:0]  pos_a,
    output logic [POSW-1:0]  pos_b,
    output logic [POSW-1:0]  pos_s,
    output logic             busy,
    output logic             done
);
    state_e            state_q, state_d;
    logic [POSW-1:0]   cnt_q, wm1_q, off_a_q, off_b_q, off_s_q;
    logic [WBITS-1:0]  cmp_q, mask_q;
    logic              idle_cmd;

    function automatic logic [POSW-1:0] wrap_pos(input logic [POSW-1:0] base,
                                                 input logic [POSW-1:0] step);
        logic [POSW:0] s;
        s = {1'b0, base} + {1'b0, step};
        if (s >= (POSW+1)'(WBITS)) s = s - (POSW+1)'(WBITS);
        return s[POSW-1:0];
    endfunction

    assign idle_cmd = (state_q == ST_IDLE) && cmd_valid;

    // State register and per-command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wm1_q   <= '0;
            off_a_q <= '0;
            off_b_q <= '0;
            off_s_q <= '0;
            cmp_q   <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (search_init || add_init) begin
                cnt_q   <= '0;
                wm1_q   <= cmd_wm1;
                off_a_q <= cmd_off_a;
                off_b_q <= cmd_off_b;
                off_s_q <= cmd_off_s;
                cmp_q   <= cmd_cmp;
                mask_q  <= cmd_mask;
            end else if (search_step || add_step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid && op_e'(cmd_op) == OP_SEARCH) state_d = ST_SEARCH;
                else if (cmd_valid && op_e'(cmd_op) == OP_ADD) state_d = ST_ADD;
            end
            ST_SEARCH, ST_ADD: begin
                if (cnt_q == wm1_q) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        word_we     = idle_cmd && (op_e'(cmd_op) == OP_WRITE);
        search_init = idle_cmd && (op_e'(cmd_op) == OP_SEARCH);
        add_init    = idle_cmd && (op_e'(cmd_op) == OP_ADD);
        search_step = (state_q == ST_SEARCH);
        add_step    = (state_q == ST_ADD);
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_DONE);
        cmp_bit     = cmp_q[cnt_q];
        mask_bit    = mask_q[cnt_q];
        pos_a       = wrap_pos(off_a_q, cnt_q);
        pos_b       = wrap_pos(off_b_q, cnt_q);
        pos_s       = wrap_pos(off_s_q, cnt_q);
    end
endmodule

// File: rtl/bitslice_assoc_proc.sv
module bitslice_assoc_proc #(
    parameter int unsigned NWORDS = 16,
    parameter int unsigned WBITS  = 32,
    localparam int unsigned IDXW  = $clog2(NWORDS),
    localparam int unsigned POSW  = $clog2(WBITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDXW-1:0]   cmd_word,
    input  logic [WBITS-1:0]  cmd_data,
    input  logic [WBITS-1:0]  cmd_mask,
    input  logic [POSW-1:0]   cmd_off_a,
    input  logic [POSW-1:0]   cmd_off_b,
    input  logic [POSW-1:0]   cmd_off_s,
    input  logic [POSW-1:0]   cmd_wm1,
    input  logic [IDXW-1:0]   rd_word,
    output logic [WBITS-1:0]  rd_data,
    output logic              busy,
    output logic              done,
    output logic [NWORDS-1:0] tags,
    output logic              any_match
);
    logic              word_we, search_init, search_step, add_init, add_step;
    logic              cmp_bit, mask_bit;
    logic [POSW-1:0]   pos_a, pos_b, pos_s;
    logic [NWORDS-1:0] slice_a, slice_b, sum_bits;

    bsap_ctrl #(.WBITS(WBITS), .POSW(POSW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cmp(cmd_data), .cmd_mask(cmd_mask), .cmd_off_a(cmd_off_a),
        .cmd_off_b(cmd_off_b), .cmd_off_s(cmd_off_s), .cmd_wm1(cmd_wm1),
        .word_we(word_we), .search_init(search_init), .search_step(search_step),
        .add_init(add_init), .add_step(add_step), .cmp_bit(cmp_bit),
        .mask_bit(mask_bit), .pos_a(pos_a), .pos_b(pos_b), .pos_s(pos_s),
        .busy(busy), .done(done)
    );

    bsap_slice_mem #(.NWORDS(NWORDS), .WBITS(WBITS), .IDXW(IDXW), .POSW(POSW)) u_mem (
        .clk(clk), .rst_n(rst_n), .word_we(word_we), .word_idx(cmd_word),
        .word_data(cmd_data), .slice_we(add_step), .pos_a(pos_a), .pos_b(pos_b),
        .pos_s(pos_s), .sum_bits(sum_bits), .slice_a(slice_a), .slice_b(slice_b),
        .rd_idx(rd_word), .rd_data(rd_data)
    );

    bsap_pe_array #(.NWORDS(NWORDS)) u_pe (
        .clk(clk), .rst_n(rst_n), .search_init(search_init), .search_step(search_step),
        .add_init(add_init), .add_step(add_step), .cmp_bit(cmp_bit),
        .mask_bit(mask_bit), .bit_a(slice_a), .bit_b(slice_b),
        .sum_bits(sum_bits), .tags(tags)
    );

    assign any_match = |tags;
endmodule

// File: rtl/bsap_checker.sv
module bsap_checker #(
    parameter int unsigned NWORDS = 16,
    parameter int unsigned WBITS  = 32,
    localparam int unsigned IDXW  = $clog2(NWORDS),
    localparam int unsigned POSW  = $clog2(WBITS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [POSW-1:0]   cmd_wm1,
    input logic              busy,
    input logic              done,
    input logic [NWORDS-1:0] tags,
    input logic [IDXW-1:0]   rd_word,
    input logic [WBITS-1:0]  rd_data
);
    logic [POSW:0]   slice_cnt;
    logic [POSW-1:0] wm1_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slice_cnt <= '0;
            wm1_seen  <= '0;
        end else if (!busy && cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2)) begin
            slice_cnt <= '0;
            wm1_seen  <= cmd_wm1;
        end else if (busy && !done) begin
            slice_cnt <= slice_cnt + 1'b1;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_W_SLICES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (slice_cnt == {1'b0, wm1_seen} + 1'b1)); // R7

    AST_TAGS_NEVER_RISE_MIDCMD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((tags & ~$past(tags)) == '0)); // R3

    AST_TAGS_HOLD_NO_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!busy) && !$past(cmd_valid && cmd_op == 2'd1)) |-> $stable(tags)); // R9

    AST_WORDS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!busy) && !$past(cmd_valid && cmd_op == 2'd0) && $stable(rd_word))
            |-> $stable(rd_data)); // R2
endmodule

bind bitslice_assoc_proc bsap_checker #(.NWORDS(NWORDS), .WBITS(WBITS)) u_bsap_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wm1(cmd_wm1), .busy(busy), .done(done), .tags(tags),
    .rd_word(rd_word), .rd_data(rd_data)
);

// File: tb/bitslice_assoc_proc_bench.sv
module bitslice_assoc_proc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [3:0]  cmd_word = '0;
    logic [31:0] cmd_data = '0;
    logic [31:0] cmd_mask = '0;
    logic [4:0]  cmd_off_a = '0, cmd_off_b = '0, cmd_off_s = '0, cmd_wm1 = '0;
    logic [3:0]  rd_word = '0;
    logic [31:0] rd_data;
    logic        busy, done, any_match;
    logic [15:0] tags;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [31:0] sh [16];

    always #10 clk = ~clk;

    bitslice_assoc_proc u_bitslice_assoc_proc (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_word(cmd_word), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
        .cmd_off_a(cmd_off_a), .cmd_off_b(cmd_off_b), .cmd_off_s(cmd_off_s),
        .cmd_wm1(cmd_wm1), .rd_word(rd_word), .rd_data(rd_data), .busy(busy),
        .done(done), .tags(tags), .any_match(any_match)
    );

    // {op, off_a, off_b, off_s, wm1, mask, src word, requirement number}
    localparam int NV = 12;
    localparam logic [61:0] TBL [NV] = '{
        {2'd1, 5'd0,  5'd0,  5'd0,  5'd31, 32'hFFFF_FFFF, 4'd0,  4'd3 },  // R3 full word
        {2'd1, 5'd8,  5'd0,  5'd0,  5'd7,  32'h0000_00FF, 4'd5,  4'd3 },  // R3 byte field
        {2'd1, 5'd28, 5'd0,  5'd0,  5'd7,  32'h0000_00F0, 4'd4,  4'd10},  // R10 wrapping search
        {2'd1, 5'd3,  5'd0,  5'd0,  5'd9,  32'h0000_0000, 4'd1,  4'd4 },  // R4 empty mask
        {2'd2, 5'd0,  5'd8,  5'd16, 5'd7,  32'h0,         4'd0,  4'd5 },  // R5 disjoint add
        {2'd1, 5'd16, 5'd0,  5'd0,  5'd7,  32'h0000_00FF, 4'd8,  4'd3 },  // R3 on sums
        {2'd2, 5'd0,  5'd16, 5'd0,  5'd15, 32'h0,         4'd0,  4'd6 },  // R6 in place
        {2'd2, 5'd0,  5'd0,  5'd0,  5'd31, 32'h0,         4'd0,  4'd5 },  // R5 carry dropped
        {2'd2, 5'd28, 5'd8,  5'd16, 5'd7,  32'h0,         4'd0,  4'd10},  // R10 A wraps
        {2'd2, 5'd0,  5'd8,  5'd30, 5'd5,  32'h0,         4'd0,  4'd10},  // R10 S wraps
        {2'd1, 5'd30, 5'd0,  5'd0,  5'd5,  32'h0000_003F, 4'd2,  4'd10},  // R10 search wrap
        {2'd1, 5'd0,  5'd0,  5'd0,  5'd31, 32'hFFFF_FFFF, 4'd12, 4'd3 }   // R3 shared value
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] init_val(input int w);
        logic [31:0] t;
        t = 32'h9E37_79B9 * 32'(w + 1);
        return (w % 4 == 0) ? 32'hCAFE_1234 : t;
    endfunction

    // Drives a command at a falling edge; returns cycles until done (0 for write/no-op)
    task automatic issue(input logic [1:0] op, input logic [3:0] wd, input logic [31:0] data,
                         input logic [31:0] mask, input logic [4:0] oa, input logic [4:0] ob,
                         input logic [4:0] os, input logic [4:0] wm1, output int lat);
        cmd_valid = 1'b1; cmd_op = op; cmd_word = wd; cmd_data = data; cmd_mask = mask;
        cmd_off_a = oa; cmd_off_b = ob; cmd_off_s = os; cmd_wm1 = wm1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        if (op == 2'd1 || op == 2'd2) begin
            while (!done && lat < 100) begin
                @(negedge clk);
                lat++;
            end
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] model_search(input logic [4:0] oa, input logic [4:0] wm1,
                                                 input logic [31:0] mask, input logic [31:0] cmp);
        logic [15:0] r;
        for (int w = 0; w < 16; w++) begin
            r[w] = 1'b1;
            for (int i = 0; i <= int'(wm1); i++)
                if (mask[i] && sh[w][(int'(oa) + i) % 32] != cmp[i]) r[w] = 1'b0;
        end
        return r;
    endfunction

    task automatic model_add(input logic [4:0] oa, input logic [4:0] ob,
                             input logic [4:0] os, input logic [4:0] wm1);
        for (int w = 0; w < 16; w++) begin
            logic [31:0] a, b, s;
            a = '0; b = '0;
            for (int i = 0; i <= int'(wm1); i++) begin
                a[i] = sh[w][(int'(oa) + i) % 32];
                b[i] = sh[w][(int'(ob) + i) % 32];
            end
            s = a + b;
            for (int i = 0; i <= int'(wm1); i++) sh[w][(int'(os) + i) % 32] = s[i];
        end
    endtask

    task automatic check_words(input string req);
        for (int w = 0; w < 16; w++) begin
            rd_word = 4'(w);
            #1;
            chk(req, rd_data, sh[w]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [15:0] tag_before;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {28'd0, busy, done, any_match, 1'b0}, 32'd0);
        chk("R1", {16'd0, tags}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int w = 0; w < 16; w++) sh[w] = '0;
        check_words("R1");

        // R2 loading
        for (int w = 0; w < 16; w++) begin
            sh[w] = init_val(w);
            issue(2'd0, 4'(w), sh[w], '0, '0, '0, '0, '0, lat);
        end
        check_words("R2");

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic [4:0]  oa, ob, os, wm1;
            logic [31:0] mask, cmp;
            logic [3:0]  src;
            string       rq;
            {op, oa, ob, os, wm1, mask, src} = TBL[v][61:4];
            rq = $sformatf("R%0d", TBL[v][3:0]);
            cmp = '0;
            for (int i = 0; i <= int'(wm1); i++) cmp[i] = sh[src][(int'(oa) + i) % 32];
            tag_before = tags;
            issue(op, '0, cmp, mask, oa, ob, os, wm1, lat);
            chk("R7", 32'(lat), 32'(int'(wm1) + 1));
            if (op == 2'd1) begin
                logic [15:0] exp_t;
                exp_t = model_search(oa, wm1, mask, cmp);
                chk(rq, {16'd0, tags}, {16'd0, exp_t});
                chk(rq, {31'd0, any_match}, {31'd0, |exp_t});
            end else begin
                model_add(oa, ob, os, wm1);
                check_words(rq);
                chk("R9", {16'd0, tags}, {16'd0, tag_before});
            end
        end

        // R8: commands while busy are ignored
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_mask = '0; cmd_off_a = '0; cmd_wm1 = 5'd31;
        @(posedge clk);
        @(negedge clk);
        cmd_op = 2'd0; cmd_word = 4'd3; cmd_data = ~sh[3];
        @(negedge clk);
        cmd_op = 2'd2; cmd_off_a = 5'd0; cmd_off_b = 5'd0; cmd_off_s = 5'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R8", {31'd0, busy}, 32'd0);
        check_words("R8");
        chk("R4", {16'd0, tags}, 32'h0000_FFFF);

        // R9: a write leaves tags alone
        sh[5] = 32'h0BAD_F00D;
        issue(2'd0, 4'd5, sh[5], '0, '0, '0, '0, '0, lat);
        chk("R9", {16'd0, tags}, 32'h0000_FFFF);
        chk("R2", sh[5], sh[5]);
        rd_word = 4'd5; #1;
        chk("R2", rd_data, 32'h0BAD_F00D);

        // R11: no-op changes nothing and raises no busy
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_word = 4'd6; cmd_data = 32'h1234_5678;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R11", {30'd0, busy, done}, 32'd0);
        chk("R11", {16'd0, tags}, 32'h0000_FFFF);
        check_words("R11");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule